// File: doc/BRIEF.md
# Block-Cipher Sequencing Controller

This block sits between a 32-bit register bus and a 128-bit block-cipher core. Software configures a direction (encrypt or decrypt), a chaining scheme (ECB or CBC), a word-ordering transform, a 128-bit key and a 128-bit initialization vector while the unit is switched off. It then switches the unit on and streams each block through one data-input register as four word writes, most significant word first. The fourth write assembles the block, applies CBC chaining where selected and launches the core through a one-cycle start pulse. The core answers with a done pulse and a 128-bit result.

When the core finishes, a completion flag rises in the status register. Software polls it and collects the result through four reads of one data-output register, most significant word first. It then writes a clear bit in the control register, and the next block runs with the same key and the running chaining value, with no reconfiguration. Data-input writes that arrive while a block is computing, or before the flag is cleared, are dropped and latch a sticky error bit. Switching the unit off aborts any block in flight and returns every counter and flag to zero.

Top module: `blkcipher_seq`

## Requirements
- R1: After reset, reads of the control register (address 0), the status register (address 1) and the data-output register (address 3) return 0, and coreStart is low.
- R2: Key word i (address 4+i, word 3 most significant) and IV word i (address 8+i) are written only while the enable bit is clear. The mode, chaining and data-type fields of a control write load only when enable is clear before that write. Such writes made while enabled are ignored. Control layout: bit 0 enable, bits 2:1 mode, bits 4:3 chaining, bits 6:5 data type, bit 7 flag clear (write-1, reads 0).
- R3: Four writes to the data-input register (address 2) fill a block, the first write taking bits 127:96. The fourth write starts the core with a single-cycle coreStart. coreDecrypt follows bit 1 of the mode field: code 00 encrypts, code 10 decrypts.
- R4: With chaining code 00 (ECB), or any code other than 01, the core receives the assembled block, and the result is the core output.
- R5: In CBC encryption (chaining 01, mode 00), the core receives the block XOR the chaining value. The chaining value is loaded from the IV when enable is set and is replaced by each ciphertext.
- R6: In CBC decryption (chaining 01, mode 10), the result is the core output XOR the chaining value, and the ciphertext just written becomes the new chaining value.
- R7: Status bit 0 (completion flag) sets when the core signals done. Four data-output reads then return result words 3 down to 0. The data-output register reads 0 while no result is held.
- R8: Writing a control value with bit 7 set while the flag is up clears the flag and both word counters, and the next block is processed with the same key.
- R9: Data-input writes while computing (status bit 2 busy) or while the flag is set are ignored and set status bit 1. This error bit stays set until enable is cleared.
- R10: Clearing enable aborts any block, clears the word counters, busy, the flag and the error bit, and drops any later core done pulse.
- R11: The data-type field transforms each input word as written and each output word as read: 00 unchanged, 01 swap 16-bit halves, 10 reverse byte order, 11 reverse bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe; a data-output read advances the read counter |
| regAddr | input | ADDR_W | Word address of the register |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from address while regRdEn is high |
| coreStart | output | 1 | One-cycle pulse launching the core |
| coreDecrypt | output | 1 | Direction for the core, high for decryption |
| coreKey | output | 128 | Key held for the core |
| coreIn | output | 128 | Block presented to the core |
| coreDone | input | 1 | One-cycle pulse from the core when the result is ready |
| coreOut | input | 128 | Core result, valid with coreDone |

## Verification
The bench builds the block with its default address width of 4, which covers the full register map including both the key and IV banks. It attaches a core model whose latency is a bench localparam of 3 cycles. That latency leaves a window in which data-input writes land during computation, and in which a done pulse can arrive after the unit has been switched off. The vector table runs two-block sequences in all four combinations of direction and chaining, each with a different data-type code, so the chaining value is seen to carry from one block to the next.

// File: rtl/blkseq_pkg.sv
package blkseq_pkg;
  localparam int WORD_W    = 32;
  localparam int BLK_WORDS = 4;
  localparam int BLK_W     = WORD_W * BLK_WORDS;
  localparam int CNT_W     = $clog2(BLK_WORDS);

  localparam int ADR_CTRL = 0;
  localparam int ADR_STAT = 1;
  localparam int ADR_DIN  = 2;
  localparam int ADR_DOUT = 3;
  localparam int ADR_KEY  = 4;
  localparam int ADR_IV   = 8;

  typedef enum logic [1:0] {
    ST_OFF,
    ST_FILL,
    ST_RUN,
    ST_HOLD
  } seqState_t;

  typedef struct packed {
    logic             shiftIn;
    logic             seedChain;
    logic             capture;
    logic             cfgWrOk;
    logic             cbcEnc;
    logic             cbcDec;
    logic [1:0]       dtype;
    logic [CNT_W-1:0] outSel;
  } seqStrobe_t;

  function automatic logic [WORD_W-1:0] swapWord(input logic [WORD_W-1:0] w,
                                                  input logic [1:0] dt);
    logic [WORD_W-1:0] r;
    case (dt)
      2'b00: r = w;
      2'b01: r = {w[15:0], w[31:16]};
      2'b10: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      default: begin
        for (int b = 0; b < WORD_W; b++) r[b] = w[WORD_W-1-b];
      end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/blkseq_ctl.sv
module blkseq_ctl
  import blkseq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [7:0]        ctlWdata,
  input  logic              coreDone,
  output seqStrobe_t        strobe,
  output logic              coreStart,
  output logic              coreDecrypt,
  output logic              enable,
  output logic              busy,
  output logic              doneFlag,
  output logic              errFlag,
  output logic              outValid,
  output logic [7:0]        ctrlRd,
  output logic [7:0]        statRd
);
  seqState_t        state;
  logic [1:0]       modeSel, chainSel, dtypeSel;
  logic [CNT_W-1:0] inCnt, outCnt;
  logic             startPulse;

  logic wrCtrl, wrDin, rdDout;
  assign wrCtrl = regWrEn && (regAddr == ADDR_W'(ADR_CTRL));
  assign wrDin  = regWrEn && (regAddr == ADDR_W'(ADR_DIN));
  assign rdDout = regRdEn && (regAddr == ADDR_W'(ADR_DOUT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_OFF;
      enable     <= 1'b0;
      modeSel    <= '0;
      chainSel   <= '0;
      dtypeSel   <= '0;
      inCnt      <= '0;
      outCnt     <= '0;
      doneFlag   <= 1'b0;
      errFlag    <= 1'b0;
      startPulse <= 1'b0;
    end else begin
      startPulse <= 1'b0;
      if (wrCtrl) begin
        enable <= ctlWdata[0];
        if (!enable) begin
          modeSel  <= ctlWdata[2:1];
          chainSel <= ctlWdata[4:3];
          dtypeSel <= ctlWdata[6:5];
        end
      end
      if (wrCtrl && !ctlWdata[0]) begin
        state    <= ST_OFF;
        inCnt    <= '0;
        outCnt   <= '0;
        doneFlag <= 1'b0;
        errFlag  <= 1'b0;
      end else begin
        case (state)
          ST_OFF: begin
            if (wrCtrl) begin
              state <= ST_FILL;
              inCnt <= '0;
            end
          end
          ST_FILL: begin
            if (wrDin) begin
              inCnt <= inCnt + 1'b1;
              if (inCnt == CNT_W'(BLK_WORDS - 1)) begin
                state      <= ST_RUN;
                startPulse <= 1'b1;
              end
            end
          end
          ST_RUN: begin
            if (wrDin) errFlag <= 1'b1;
            if (coreDone) begin
              state    <= ST_HOLD;
              doneFlag <= 1'b1;
              outCnt   <= '0;
            end
          end
          default: begin
            if (wrDin) errFlag <= 1'b1;
            if (rdDout) outCnt <= outCnt + 1'b1;
            if (wrCtrl && ctlWdata[7]) begin
              state    <= ST_FILL;
              doneFlag <= 1'b0;
              inCnt    <= '0;
              outCnt   <= '0;
            end
          end
        endcase
      end
    end
  end

  assign coreStart   = startPulse;
  assign coreDecrypt = modeSel[1];
  assign busy        = (state == ST_RUN);
  assign outValid    = (state == ST_HOLD);
  assign ctrlRd      = {1'b0, dtypeSel, chainSel, modeSel, enable};
  assign statRd      = {5'b0, busy, errFlag, doneFlag};

  always_comb begin
    strobe.shiftIn   = wrDin && (state == ST_FILL);
    strobe.seedChain = wrCtrl && ctlWdata[0] && !enable;
    strobe.capture   = (state == ST_RUN) && coreDone;
    strobe.cfgWrOk   = !enable;
    strobe.cbcEnc    = (chainSel == 2'b01) && !modeSel[1];
    strobe.cbcDec    = (chainSel == 2'b01) && modeSel[1];
    strobe.dtype     = dtypeSel;
    strobe.outSel    = outCnt;
  end
endmodule

// File: rtl/blkseq_dp.sv
module blkseq_dp
  import blkseq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WORD_W-1:0] regWdata,
  input  logic [BLK_W-1:0]  coreOut,
  output logic [BLK_W-1:0]  coreKey,
  output logic [BLK_W-1:0]  coreIn,
  output logic [WORD_W-1:0] outWord
);
  logic [BLK_W-1:0] ivFlat;
  logic [BLK_W-1:0] inBlock, chainVal, result;

  for (genvar i = 0; i < BLK_WORDS; i++) begin : g_cfgWord
    logic [WORD_W-1:0] keyW, ivW;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        keyW <= '0;
        ivW  <= '0;
      end else if (regWrEn && strobe.cfgWrOk) begin
        if (regAddr == ADDR_W'(ADR_KEY + i)) keyW <= regWdata;
        if (regAddr == ADDR_W'(ADR_IV + i))  ivW  <= regWdata;
      end
    end
    assign coreKey[i*WORD_W +: WORD_W] = keyW;
    assign ivFlat[i*WORD_W +: WORD_W]  = ivW;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inBlock  <= '0;
      chainVal <= '0;
      result   <= '0;
    end else begin
      if (strobe.shiftIn)
        inBlock <= {inBlock[BLK_W-WORD_W-1:0], swapWord(regWdata, strobe.dtype)};
      if (strobe.seedChain)
        chainVal <= ivFlat;
      else if (strobe.capture && strobe.cbcEnc)
        chainVal <= coreOut;
      else if (strobe.capture && strobe.cbcDec)
        chainVal <= inBlock;
      if (strobe.capture)
        result <= strobe.cbcDec ? (coreOut ^ chainVal) : coreOut;
    end
  end

  assign coreIn  = strobe.cbcEnc ? (inBlock ^ chainVal) : inBlock;
  assign outWord = swapWord(result[(BLK_WORDS-1-int'(strobe.outSel))*WORD_W +: WORD_W],
                            strobe.dtype);
endmodule

// File: rtl/blkcipher_seq.sv
module blkcipher_seq
  import blkseq_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              coreStart,
  output logic              coreDecrypt,
  output logic [127:0]      coreKey,
  output logic [127:0]      coreIn,
  input  logic              coreDone,
  input  logic [127:0]      coreOut
);
  seqStrobe_t        strobe;
  logic              enable, busy, doneFlag, errFlag, outValid;
  logic [7:0]        ctrlRd, statRd;
  logic [WORD_W-1:0] outWord;

  blkseq_ctl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .ctlWdata(regWdata[7:0]), .coreDone(coreDone),
    .strobe(strobe), .coreStart(coreStart), .coreDecrypt(coreDecrypt),
    .enable(enable), .busy(busy), .doneFlag(doneFlag), .errFlag(errFlag),
    .outValid(outValid), .ctrlRd(ctrlRd), .statRd(statRd)
  );

  blkseq_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWdata(regWdata), .coreOut(coreOut),
    .coreKey(coreKey), .coreIn(coreIn), .outWord(outWord)
  );

  always_comb begin
    regRdata = '0;
    if (regRdEn) begin
      if (regAddr == ADDR_W'(ADR_CTRL))      regRdata = {24'b0, ctrlRd};
      else if (regAddr == ADDR_W'(ADR_STAT)) regRdata = {24'b0, statRd};
      else if (regAddr == ADDR_W'(ADR_DOUT) && outValid) regRdata = outWord;
    end
  end
endmodule

// File: rtl/blkseq_chk.sv
module blkseq_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic busy,
  input logic doneFlag,
  input logic errFlag,
  input logic coreStart,
  input logic coreDone
);
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    coreStart |=> !coreStart);

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    coreStart |-> busy);

  p_flag_on_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && coreDone) |=> (doneFlag || !enable) && !busy);

  p_busy_excl_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !doneFlag);

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    errFlag |=> (errFlag || !enable));

  p_off_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!busy && !doneFlag && !errFlag && !coreStart));
endmodule

bind blkcipher_seq blkseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .busy(busy),
  .doneFlag(doneFlag), .errFlag(errFlag), .coreStart(coreStart),
  .coreDone(coreDone)
);

// File: tb/blkcipher_seq_tb.sv
module blkcipher_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CORE_LAT   = 3;
  localparam int NVEC       = 4;

  typedef struct packed {
    logic [1:0]   mode;
    logic [1:0]   chain;
    logic [1:0]   dtype;
    logic [127:0] key;
    logic [127:0] iv;
    logic [127:0] b0;
    logic [127:0] b1;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'b00, 2'b00, 2'b00, 128'h000102030405060708090a0b0c0d0e0f,
      128'h0, 128'h00112233445566778899aabbccddeeff,
      128'hdeadbeefcafef00d0123456789abcdef},
    '{2'b00, 2'b01, 2'b01, 128'h2b7e151628aed2a6abf7158809cf4f3c,
      128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0, 128'h6bc1bee22e409f96e93d7e117393172a,
      128'hae2d8a571e03ac9c9eb76fac45af8e51},
    '{2'b10, 2'b00, 2'b10, 128'h8e73b0f7da0e6452c810f32b809079e5,
      128'h0, 128'h30c81c46a35ce411e5fbc1191a0a52ef,
      128'hf69f2445df4f9b17ad2b417be66c3710},
    '{2'b10, 2'b01, 2'b11, 128'h603deb1015ca71be2b73aef0857d7781,
      128'h000102030405060708090a0b0c0d0e0f, 128'h7649abac8119b246cee98e9b12e9197d,
      128'h5086cb9b507219ee95db113a917678b2}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0]   regAddr = '0;
  logic [31:0]  regWdata = '0;
  logic [31:0]  regRdata;
  logic         coreStart, coreDecrypt, coreDone;
  logic [127:0] coreKey, coreIn, coreOut;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkcipher_seq u_dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWdata(regWdata), .regRdata(regRdata),
    .coreStart(coreStart), .coreDecrypt(coreDecrypt), .coreKey(coreKey),
    .coreIn(coreIn), .coreDone(coreDone), .coreOut(coreOut)
  );

  // toy reversible core: rotate left 8 then XOR key, and its inverse
  function automatic logic [127:0] tEnc(input logic [127:0] x, input logic [127:0] k);
    return {x[119:0], x[127:120]} ^ k;
  endfunction
  function automatic logic [127:0] tDec(input logic [127:0] y, input logic [127:0] k);
    logic [127:0] z;
    z = y ^ k;
    return {z[7:0], z[127:8]};
  endfunction

  int           latCnt;
  logic [127:0] latIn, latKey;
  logic         latDec;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latCnt <= 0; coreDone <= 1'b0; coreOut <= '0;
      latIn <= '0; latKey <= '0; latDec <= 1'b0;
    end else begin
      coreDone <= 1'b0;
      if (coreStart) begin
        latCnt <= CORE_LAT; latIn <= coreIn; latKey <= coreKey; latDec <= coreDecrypt;
      end else if (latCnt != 0) begin
        latCnt <= latCnt - 1;
        if (latCnt == 1) begin
          coreDone <= 1'b1;
          coreOut  <= latDec ? tDec(latIn, latKey) : tEnc(latIn, latKey);
        end
      end
    end
  end

  function automatic logic [31:0] tSwap(input logic [31:0] w, input logic [1:0] d);
    logic [31:0] r;
    case (d)
      2'd0: r = w;
      2'd1: r = {w[15:0], w[31:16]};
      2'd2: r = {w[7:0], w[15:8], w[23:16], w[31:24]};
      default: for (int b = 0; b < 32; b++) r[b] = w[31-b];
    endcase
    return r;
  endfunction

  function automatic logic [127:0] tSwapBlk(input logic [127:0] x, input logic [1:0] d);
    return {tSwap(x[127:96], d), tSwap(x[95:64], d), tSwap(x[63:32], d), tSwap(x[31:0], d)};
  endfunction

  // expected four-word readout for one written block; updates the chaining value
  task automatic modelBlk(input logic [1:0] mode, input logic [1:0] chain,
                          input logic [1:0] dt, input logic [127:0] key,
                          inout logic [127:0] chv, input logic [127:0] blk,
                          output logic [127:0] exp);
    logic [127:0] bin, res;
    bin = tSwapBlk(blk, dt);
    if (!mode[1]) begin
      res = tEnc((chain == 2'b01) ? (bin ^ chv) : bin, key);
      if (chain == 2'b01) chv = res;
    end else begin
      res = tDec(bin, key);
      if (chain == 2'b01) begin res = res ^ chv; chv = bin; end
    end
    exp = tSwapBlk(res, dt);
  endtask

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic configure(input logic [1:0] mode, input logic [1:0] chain,
                           input logic [1:0] dt, input logic [127:0] key,
                           input logic [127:0] iv);
    busWrite(4'd0, 32'h0);
    for (int i = 0; i < 4; i++) busWrite(4'(4 + i), key[32*i +: 32]);
    for (int i = 0; i < 4; i++) busWrite(4'(8 + i), iv[32*i +: 32]);
    busWrite(4'd0, {25'b0, dt, chain, mode, 1'b1});
  endtask

  task automatic writeBlk(input logic [127:0] blk);
    for (int j = 3; j >= 0; j--) busWrite(4'd2, blk[32*j +: 32]);
  endtask

  task automatic waitFlag;
    logic [31:0] s;
    s = '0;
    for (int n = 0; n < 50 && !s[0]; n++) busRead(4'd1, s);
  endtask

  task automatic readBlk(output logic [127:0] got);
    logic [31:0] w;
    for (int j = 3; j >= 0; j--) begin
      busRead(4'd3, w);
      got[32*j +: 32] = w;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0]  rd;
    logic [127:0] got, exp, chv, key1;

    repeat (3) @(negedge clk);
    // R1 reset state
    busRead(4'd0, rd); check("R1 ctrl", 128'(rd), 128'h0);
    busRead(4'd1, rd); check("R1 status", 128'(rd), 128'h0);
    busRead(4'd3, rd); check("R1 dout", 128'(rd), 128'h0);
    check("R1 coreStart", 128'(coreStart), 128'h0);
    rst_n = 1'b1;
    busRead(4'd0, rd); check("R1 ctrl after release", 128'(rd), 128'h0);

    // vector table: R3 R4 R5 R6 R7 R8 R11
    for (int v = 0; v < NVEC; v++) begin
      configure(VECS[v].mode, VECS[v].chain, VECS[v].dtype, VECS[v].key, VECS[v].iv);
      chv = VECS[v].iv;
      for (int b = 0; b < 2; b++) begin
        writeBlk(b == 0 ? VECS[v].b0 : VECS[v].b1);
        waitFlag();
        readBlk(got);
        modelBlk(VECS[v].mode, VECS[v].chain, VECS[v].dtype, VECS[v].key, chv,
                 b == 0 ? VECS[v].b0 : VECS[v].b1, exp);
        check($sformatf("R4 R5 R6 R7 R11 vec%0d blk%0d", v, b), got, exp);
        busWrite(4'd0, 32'h81);  // R8 clear flag, keep enable
      end
    end

    // R3 direction output follows mode bit 1 (last vector decrypts)
    check("R3 coreDecrypt", 128'(coreDecrypt), 128'h1);

    // R2 config locked while enabled
    key1 = 128'h11112222333344445555666677778888;
    configure(2'b00, 2'b00, 2'b00, key1, 128'h0);
    busWrite(4'd4, 32'hffffffff);
    check("R2 key write ignored", coreKey, key1);
    busWrite(4'd0, 32'h05);
    busRead(4'd0, rd);
    check("R2 mode write ignored", 128'(rd), 128'h01);

    // R9 writes during computation and while flag set
    writeBlk(128'h0123456789abcdeffedcba9876543210);
    busWrite(4'd2, 32'hbadbad00);
    busRead(4'd1, rd);
    check("R9 error set while busy", 128'(rd[1]), 128'h1);
    waitFlag();
    busWrite(4'd2, 32'hbadbad11);
    readBlk(got);
    chv = '0;
    modelBlk(2'b00, 2'b00, 2'b00, key1, chv, 128'h0123456789abcdeffedcba9876543210, exp);
    check("R9 result unaffected", got, exp);
    busWrite(4'd0, 32'h81);
    busRead(4'd1, rd);
    check("R8 R9 flag clear keeps error", 128'(rd[1:0]), 128'h2);
    busRead(4'd3, rd);
    check("R7 dout zero without result", 128'(rd), 128'h0);

    // R10 abort mid-block
    busWrite(4'd2, 32'haaaaaaaa);
    busWrite(4'd2, 32'hbbbbbbbb);
    busWrite(4'd0, 32'h0);
    busRead(4'd1, rd);
    check("R10 R9 status cleared on disable", 128'(rd), 128'h0);
    busWrite(4'd0, 32'h01);
    writeBlk(128'h00000001000000020000000300000004);
    waitFlag();
    readBlk(got);
    chv = '0;
    modelBlk(2'b00, 2'b00, 2'b00, key1, chv, 128'h00000001000000020000000300000004, exp);
    check("R10 counter restarted after abort", got, exp);

    // R10 done pulse after disable is dropped
    busWrite(4'd0, 32'h81);
    writeBlk(128'h5555aaaa5555aaaa5555aaaa5555aaaa);
    busWrite(4'd0, 32'h0);
    repeat (CORE_LAT + 3) @(negedge clk);
    busRead(4'd1, rd);
    check("R10 late done ignored", 128'(rd), 128'h0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule